// File: doc/BRIEF.md
# Converter Sample Capture Controller

This controller fills an on-chip sample buffer with one burst of converter words and then streams the buffer back to a host. The buffer holds 1536 words of 16 bits. Its words are addressed by a row index (0 to 95) and a word-in-row index (0 to 15), not by one flat binary address. The controller owns the address counter. The host only issues two commands, "begin capture" and "read back", and never supplies an address.

The control machine has four states. ST_IDLE is the state after reset. ST_CAPTURE writes each valid sample at the counter position. ST_FULL holds a complete burst. ST_READOUT sweeps every word out through the sense-enable strobe. The transitions are:
- IDLE→CAPTURE on a start command.
- CAPTURE→FULL when the 1536th word has been written.
- FULL→CAPTURE on a start command.
- FULL→READOUT on a read command when no start command is present.
- READOUT→FULL after the last word has been addressed.

The write strobe is active low and sits in the same cycle as the sample. A read word appears on the host bus one cycle after its sense-enable cycle.

Top module: `smpl_cap_ctrl`

## Requirements
- R1: After reset the controller is in ST_IDLE with mem_we_n=1, mem_sae=0, mem_row=0, mem_col=0, full=0, done=0 and rd_valid=0.
- R2: cmd_start in ST_IDLE or ST_FULL moves to ST_CAPTURE, sets the address to row 0 / column 0 and clears done on the next edge.
- R3: In ST_CAPTURE a cycle with smp_valid=1 drives mem_we_n=0 in that same cycle, with mem_wdata equal to smp_data. A cycle with smp_valid=0 keeps mem_we_n=1 and leaves the address unchanged.
- R4: Each write or read step moves mem_col from 0 up to 15. After column 15 it returns to column 0 and mem_row goes up by one. After row 95 / column 15 the address returns to row 0 / column 0. mem_row never exceeds 95.
- R5: The edge that writes the 1536th word of a burst enters ST_FULL, with full=1 and done=1. full is 1 only in ST_FULL, and full=1 implies done=1.
- R6: A valid sample in ST_IDLE, ST_FULL or ST_READOUT is dropped: mem_we_n stays 1 and the stored words are unchanged.
- R7: cmd_read in ST_FULL (without cmd_start) enters ST_READOUT. There mem_sae=1 in every cycle while the address sweeps all 1536 positions from row 0 / column 0 in R4 order. The edge that follows the last position returns the controller to ST_FULL with done still 1. mem_sae and a low mem_we_n never coincide.
- R8: rd_valid is 1 exactly in the cycle after a mem_sae cycle. rd_data then equals the word stored at the address presented in that mem_sae cycle. At all other times rd_data is 0.
- R9: In ST_FULL, cmd_start wins over cmd_read. Commands are ignored in ST_CAPTURE and ST_READOUT, and cmd_read is ignored in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 16 | Converter sample word |
| smp_valid | input | 1 | Sample word present this cycle |
| cmd_start | input | 1 | Begin a new capture burst |
| cmd_read | input | 1 | Read the captured burst back |
| mem_row | output | 7 | Buffer row index |
| mem_col | output | 4 | Word index within the row |
| mem_we_n | output | 1 | Active-low buffer write strobe |
| mem_sae | output | 1 | Sense-amplifier (read) enable |
| mem_wdata | output | 16 | Buffer write data |
| mem_rdata | input | 16 | Buffer read data, one cycle after mem_sae |
| rd_data | output | 16 | Word returned to the host |
| rd_valid | output | 1 | rd_data holds a buffer word |
| full | output | 1 | Complete burst held, controller in ST_FULL |
| done | output | 1 | Last capture burst finished |

## Verification
The assertions assume that the buffer model answers every mem_sae cycle with the addressed word on the next edge. They also assume that reset holds for at least one edge, so that the delayed-strobe relations start from zero.

The stimulus keeps within these assumptions:
- A synchronous memory model answers each mem_sae cycle on the following edge.
- Commands and samples change only just after a clock edge.
- Commands are pulsed in every state, including in the same cycle as each other, so that the priority and ignore rules are exercised.
- Captures are run both with sparse gaps and with back-to-back samples.

// File: rtl/smpl_cap_pkg.sv
package smpl_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FULL    = 2'd2,
        ST_READOUT = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cap_addr_ctr.sv
// Row / word-in-row address counter; rows wrap at ROWS, not at a power of two.
module cap_addr_ctr #(
    parameter int ROWS = 96,
    parameter int WPR  = 16,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(WPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          last
);
    logic row_end;
    logic col_end;

    assign col_end = (col == CW'(WPR - 1));
    assign row_end = (row == RW'(ROWS - 1));
    assign last    = row_end && col_end;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row <= '0;
            col <= '0;
        end else if (inc) begin
            if (col_end) begin
                col <= '0;
                row <= row_end ? '0 : row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end
endmodule

// File: rtl/cap_fsm.sv
// Control machine: state register, next-state logic, output strobes.
module cap_fsm
    import smpl_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_cmd,
    input  logic smp_valid,
    input  logic last,
    output logic we_n,
    output logic sae,
    output logic ctr_clr,
    output logic ctr_inc,
    output logic full,
    output logic done
);
    cap_state_e state;
    cap_state_e state_nx;
    logic       done_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= done_nx;
        end
    end

    always_comb begin
        state_nx = state;
        done_nx  = done;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_CAPTURE;
                    done_nx  = 1'b0;
                end
            end
            ST_CAPTURE: begin
                if (smp_valid && last) begin
                    state_nx = ST_FULL;
                    done_nx  = 1'b1;
                end
            end
            ST_FULL: begin
                if (start) begin
                    state_nx = ST_CAPTURE;
                    done_nx  = 1'b0;
                end else if (rd_cmd) begin
                    state_nx = ST_READOUT;
                end
            end
            ST_READOUT: begin
                if (last) state_nx = ST_FULL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        we_n    = 1'b1;
        sae     = 1'b0;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        full    = (state == ST_FULL);
        unique case (state)
            ST_IDLE:    ctr_clr = start;
            ST_CAPTURE: begin
                we_n    = ~smp_valid;
                ctr_inc = smp_valid;
            end
            ST_FULL:    ctr_clr = start | rd_cmd;
            ST_READOUT: begin
                sae     = 1'b1;
                ctr_inc = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cap_rd_pipe.sv
// Aligns the read qualifier with the buffer's one-cycle read latency.
module cap_rd_pipe #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sae,
    input  logic [DW-1:0] mem_rdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= sae;
    end

    assign rd_data = rd_valid ? mem_rdata : '0;
endmodule

// File: rtl/smpl_cap_ctrl.sv
module smpl_cap_ctrl #(
    parameter int DW   = 16,
    parameter int ROWS = 96,
    parameter int WPR  = 16,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(WPR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_data,
    input  logic          smp_valid,
    input  logic          cmd_start,
    input  logic          cmd_read,
    output logic [RW-1:0] mem_row,
    output logic [CW-1:0] mem_col,
    output logic          mem_we_n,
    output logic          mem_sae,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          full,
    output logic          done
);
    logic ctr_clr;
    logic ctr_inc;
    logic ctr_last;

    cap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .rd_cmd    (cmd_read),
        .smp_valid (smp_valid),
        .last      (ctr_last),
        .we_n      (mem_we_n),
        .sae       (mem_sae),
        .ctr_clr   (ctr_clr),
        .ctr_inc   (ctr_inc),
        .full      (full),
        .done      (done)
    );

    cap_addr_ctr #(.ROWS(ROWS), .WPR(WPR)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .row   (mem_row),
        .col   (mem_col),
        .last  (ctr_last)
    );

    cap_rd_pipe #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sae       (mem_sae),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign mem_wdata = smp_data;
endmodule

// File: rtl/smpl_cap_chk.sv
module smpl_cap_chk #(
    parameter int ROWS = 96,
    parameter int WPR  = 16,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(WPR)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          mem_we_n,
    input logic          mem_sae,
    input logic [RW-1:0] mem_row,
    input logic [CW-1:0] mem_col,
    input logic          full,
    input logic          done,
    input logic          rd_valid
);
    a_r3_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> smp_valid);

    a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_row) < ROWS);

    a_r4_col_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && int'(mem_col) != WPR - 1) |=> int'(mem_col) == int'($past(mem_col)) + 1);

    a_r5_full_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> done);

    a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> mem_we_n);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sae |-> mem_we_n);

    a_r8_valid_after_sae: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sae |=> rd_valid);

    a_r8_valid_only_after_sae: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_sae));
endmodule

bind smpl_cap_ctrl smpl_cap_chk #(.ROWS(ROWS), .WPR(WPR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mem_we_n  (mem_we_n),
    .mem_sae   (mem_sae),
    .mem_row   (mem_row),
    .mem_col   (mem_col),
    .full      (full),
    .done      (done),
    .rd_valid  (rd_valid)
);

// File: tb/smpl_cap_ctrl_tb.sv
`timescale 1ns/1ps
module smpl_cap_ctrl_tb;
    localparam int DEPTH = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [6:0]  mem_row;
    logic [3:0]  mem_col;
    logic        mem_we_n;
    logic        mem_sae;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        full;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    smpl_cap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .cmd_start(cmd_start), .cmd_read(cmd_read), .mem_row(mem_row),
        .mem_col(mem_col), .mem_we_n(mem_we_n), .mem_sae(mem_sae),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .full(full), .done(done)
    );

    // synchronous buffer model
    logic [15:0] buf_mem [0:DEPTH-1];
    initial for (int i = 0; i < DEPTH; i++) buf_mem[i] = '0;
    always @(posedge clk) begin
        if (!mem_we_n) buf_mem[int'(mem_row) * 16 + int'(mem_col)] <= mem_wdata;
        if (mem_sae)   mem_rdata <= buf_mem[int'(mem_row) * 16 + int'(mem_col)];
    end

    // behavioural reference: 0 idle, 1 capture, 2 full, 3 readout
    int          ms = 0;
    int          mc = 0;
    bit          md = 0;
    bit          mrv = 0;
    logic [15:0] mrd = '0;
    logic [15:0] gold [0:DEPTH-1];
    initial for (int i = 0; i < DEPTH; i++) gold[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mc = 0; md = 0; mrv = 0; mrd = '0;
        end else begin
            mrv = (ms == 3);
            mrd = (ms == 3) ? gold[mc] : 16'h0;
            case (ms)
                0: if (cmd_start) begin ms = 1; mc = 0; md = 0; end
                1: if (smp_valid) begin
                       gold[mc] = smp_data;
                       if (mc == DEPTH - 1) begin ms = 2; md = 1; mc = 0; end
                       else mc++;
                   end
                2: if (cmd_start) begin ms = 1; mc = 0; md = 0; end
                   else if (cmd_read) begin ms = 3; mc = 0; end
                3: if (mc == DEPTH - 1) begin ms = 2; mc = 0; end
                   else mc++;
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 write strobe", 32'(mem_we_n), 32'(!(ms == 1 && smp_valid)));
            if (!mem_we_n) chk("R3 write data", 32'(mem_wdata), 32'(smp_data));
            chk("R7 sense enable", 32'(mem_sae), 32'(ms == 3));
            chk("R4 row", 32'(mem_row), 32'(mc / 16));
            chk("R4 col", 32'(mem_col), 32'(mc % 16));
            chk("R5 full", 32'(full), 32'(ms == 2));
            chk("R5 done", 32'(done), 32'(md));
            chk("R8 rd_valid", 32'(rd_valid), 32'(mrv));
            chk("R8 rd_data", 32'(rd_data), 32'(mrd));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic burst(input int gap, input int seed);
        int n = 0;
        int cyc = 0;
        while (n < DEPTH) begin
            smp_valid = (gap == 0) || ((cyc % gap) != 0);
            smp_data  = 16'(n * 40503 + seed);
            cmd_start = (n == 700);     // R9: ignored in capture
            cmd_read  = (n == 900);     // R9: ignored in capture
            tick();
            if (smp_valid) n++;
            cyc++;
        end
        smp_valid = 1'b0; cmd_start = 1'b0; cmd_read = 1'b0;
    endtask

    task automatic readout();
        cmd_read = 1'b1;
        tick();
        cmd_read = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            smp_valid = 1'b1;              // R6: dropped during readout
            smp_data  = 16'hDEAD ^ 16'(i);
            cmd_start = (i == 500);        // R9: ignored in readout
            tick();
        end
        smp_valid = 1'b0; cmd_start = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 we_n", 32'(mem_we_n), 32'd1);
        chk("R1 sae", 32'(mem_sae), 32'd0);
        chk("R1 row", 32'(mem_row), 32'd0);
        chk("R1 col", 32'(mem_col), 32'd0);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);

        // R9: read command in idle is ignored
        tick();
        cmd_read = 1'b1;
        tick();
        cmd_read = 1'b0;
        @(negedge clk);
        chk("R9 idle read ignored sae", 32'(mem_sae), 32'd0);
        chk("R9 idle read ignored full", 32'(full), 32'd0);

        // R6: sample in idle dropped
        tick();
        smp_valid = 1'b1; smp_data = 16'h1234;
        @(negedge clk);
        chk("R6 idle sample dropped", 32'(mem_we_n), 32'd1);
        tick();
        smp_valid = 1'b0;

        // R2 / R3: start a sparse burst
        cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
        smp_valid = 1'b1; smp_data = 16'h0;
        @(negedge clk);
        chk("R2 start row", 32'(mem_row), 32'd0);
        chk("R2 start col", 32'(mem_col), 32'd0);
        chk("R3 capture writes", 32'(mem_we_n), 32'd0);
        smp_valid = 1'b0;
        burst(7, 11);
        @(negedge clk);
        chk("R5 full after burst", 32'(full), 32'd1);
        chk("R5 done after burst", 32'(done), 32'd1);

        // R6: sample in full dropped
        tick();
        smp_valid = 1'b1; smp_data = 16'hBEEF;
        @(negedge clk);
        chk("R6 full sample dropped", 32'(mem_we_n), 32'd1);
        tick();
        smp_valid = 1'b0;

        // R7 / R8: read back whole buffer
        readout();
        @(negedge clk);
        chk("R7 back to full", 32'(full), 32'd1);
        chk("R7 done kept", 32'(done), 32'd1);

        // R9: start wins over read in full; R2 done cleared
        tick();
        cmd_start = 1'b1; cmd_read = 1'b1;
        tick();
        cmd_start = 1'b0; cmd_read = 1'b0;
        @(negedge clk);
        chk("R9 start priority sae", 32'(mem_sae), 32'd0);
        chk("R2 done cleared", 32'(done), 32'd0);
        burst(0, 977);
        readout();
        repeat (4) tick();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule